// File: doc/BRIEF.md
# Address Acknowledge and Timeout Controller

This block answers the address phase of a processor memory bus that has one master and no pipelining. It watches the active-low transfer-start strobe and the transfer-type bits. When a transfer needs no data phase, as is the case for cache-maintenance style operations, the block returns an address acknowledge a fixed number of clocks after the start. No data tenure follows.

For every other transfer the block runs a watchdog. An address decoder that recognises the address raises a claim flag, and the slave that completes the data phase raises a done flag. Either one stops the watchdog. If neither arrives within the timeout window, the block ends the access with a one-cycle transfer error acknowledge. The window corresponds to 40 microseconds and is derived from the clock frequency. Only one transfer is in flight at a time, so start strobes that arrive while the block is busy are not acted on.

Top module: `addr_ack_ctrl`

## Requirements
- R1: While reset is asserted, and after its release until a transfer causes a response, both `addr_ack_n` and `xfer_err_n` are high.
- R2: A transfer is address-only exactly when bit 1 of `xtype` (bit 0 being the LSB) is 1 in the cycle `start_n` is sampled low. The other `xtype` bits have no effect on this.
- R3: For an address-only transfer whose start is sampled at the end of cycle k, `addr_ack_n` is low during cycle k+3 only.
- R4: An address-only transfer never produces `xfer_err_n` low, even when no claim and no done ever arrive.
- R5: A transfer that is not address-only never drives `addr_ack_n` low.
- R6: A transfer that is not address-only and gets neither a claim nor a done drives `xfer_err_n` low during cycle k+TO only. TO = CLK_MHZ*TIMEOUT_US.
- R7: A claim sampled in any cycle from k+1 to k+TO-1 clears the watchdog. No error follows, even when done arrives much later.
- R8: A done sampled in any cycle from k+1 to k+TO-1 ends the access without an error.
- R9: A start sampled while a transfer is in progress is ignored, including in the cycle its acknowledge or error is driven. A start sampled in the following cycle is accepted.
- R10: `addr_ack_n` and `xfer_err_n` are never low in the same cycle, and each low pulse lasts one cycle.
- R11: A claim sampled together with the start means the watchdog never runs for that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_n | input | 1 | Active-low transfer start strobe |
| xtype | input | TT_W | Transfer-type bits; bit AO_BIT marks an address-only transfer |
| addr_claimed | input | 1 | An address decoder recognises the current address |
| data_done | input | 1 | The data phase of the current access has completed |
| addr_ack_n | output | 1 | Active-low address acknowledge pulse |
| xfer_err_n | output | 1 | Active-low transfer error acknowledge pulse |

## Verification
The bench builds the block with CLK_MHZ = 1 and TIMEOUT_US = 40. This gives a 40-cycle window instead of the 2000 cycles of the 50 MHz default. With the short window, a full expiry, and claims and dones on the last legal cycle and one cycle too late, all fit in short directed runs. The acknowledge offset stays at its default of three, so the address-only timing is checked exactly as it will be built.

// File: rtl/aac_pkg.sv
package aac_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_WAIT  = 3'd2,
    PH_CLAIM = 3'd3,
    PH_HOLD  = 3'd4
  } phase_t;
endpackage

// File: rtl/aac_span_counter.sv
module aac_span_counter #(
  parameter int SPAN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic fire
);
  localparam int CW = (SPAN > 2) ? $clog2(SPAN) : 1;
  localparam logic [CW-1:0] LAST = CW'(SPAN - 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign fire   = run && (cnt_q == LAST);
  assign cnt_en = !run || !fire;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)       cnt_d = '0;
    else if (!fire) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7
  span_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));
endmodule

// File: rtl/addr_ack_ctrl.sv
module addr_ack_ctrl #(
  parameter int TT_W       = 5,
  parameter int AO_BIT     = 1,
  parameter int ACK_DELAY  = 3,
  parameter int CLK_MHZ    = 50,
  parameter int TIMEOUT_US = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_n,
  input  logic [TT_W-1:0] xtype,
  input  logic            addr_claimed,
  input  logic            data_done,
  output logic            addr_ack_n,
  output logic            xfer_err_n
);
  import aac_pkg::*;

  localparam int TO_CYC = CLK_MHZ * TIMEOUT_US;

  phase_t phase_q, phase_d;
  logic   ack_q, ack_d, err_q, err_d;
  logic   ao_run, ao_fire, wd_run, wd_expire;

  assign ao_run = (phase_q == PH_ADDR);
  assign wd_run = (phase_q == PH_WAIT);

  aac_span_counter #(.SPAN(ACK_DELAY)) u_ack_delay (
    .clk(clk), .rst_n(rst_n), .run(ao_run), .fire(ao_fire)
  );

  aac_span_counter #(.SPAN(TO_CYC)) u_watchdog (
    .clk(clk), .rst_n(rst_n), .run(wd_run), .fire(wd_expire)
  );

  always_comb begin
    phase_d = phase_q;
    ack_d   = 1'b0;
    err_d   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (!start_n) begin
          if (xtype[AO_BIT])    phase_d = PH_ADDR;
          else if (addr_claimed) phase_d = PH_CLAIM;
          else                   phase_d = PH_WAIT;
        end
      end
      PH_ADDR: begin
        if (ao_fire) begin
          ack_d   = 1'b1;
          phase_d = PH_HOLD;
        end
      end
      PH_WAIT: begin
        if (data_done)         phase_d = PH_IDLE;
        else if (addr_claimed) phase_d = PH_CLAIM;
        else if (wd_expire) begin
          err_d   = 1'b1;
          phase_d = PH_HOLD;
        end
      end
      PH_CLAIM: begin
        if (data_done) phase_d = PH_IDLE;
      end
      PH_HOLD: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ack_q   <= ack_d;
      err_q   <= err_d;
    end
  end

  assign addr_ack_n = ~ack_q;
  assign xfer_err_n = ~err_q;

  // R10
  ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_q && err_q));
  // R10
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);
  // R5
  ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(phase_q == PH_ADDR));
  // R4
  ao_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR) |=> !err_q);
  // R6
  wd_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> !wd_run);
  // R9
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD) |=> (phase_q == PH_IDLE));
endmodule

// File: tb/tb_addr_ack_ctrl.sv
module tb_addr_ack_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_n;
  logic [4:0] xtype;
  logic       addr_claimed;
  logic       data_done;
  logic       addr_ack_n;
  logic       xfer_err_n;

  int checks = 0;
  int fails  = 0;
  int ack_at, err_at, ack_cnt, err_cnt, both_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_ack_ctrl #(.TT_W(5), .AO_BIT(1), .ACK_DELAY(3), .CLK_MHZ(1), .TIMEOUT_US(TO)) dut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .xtype(xtype),
    .addr_claimed(addr_claimed), .data_done(data_done),
    .addr_ack_n(addr_ack_n), .xfer_err_n(xfer_err_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic launch(input logic [4:0] tt, input logic claim);
    start_n = 1'b0; xtype = tt; addr_claimed = claim;
    tick();
    start_n = 1'b1; xtype = '0; addr_claimed = 1'b0;
  endtask

  // Observe cycles k+1..k+n; inputs set at i are sampled at the end of cycle k+i.
  task automatic observe(input int n, input int claim_at, input int done_at,
                         input int st_from, input int st_to, input logic [4:0] st_tt);
    ack_at = -1; err_at = -1; ack_cnt = 0; err_cnt = 0; both_cnt = 0;
    for (int i = 1; i <= n; i++) begin
      if (!addr_ack_n) begin ack_cnt++; if (ack_at < 0) ack_at = i; end
      if (!xfer_err_n) begin err_cnt++; if (err_at < 0) err_at = i; end
      if (!addr_ack_n && !xfer_err_n) both_cnt++;
      addr_claimed = (i == claim_at);
      data_done    = (i == done_at);
      start_n      = !(i >= st_from && i <= st_to);
      xtype        = (i >= st_from && i <= st_to) ? st_tt : 5'b0;
      tick();
    end
    addr_claimed = 1'b0; data_done = 1'b0; start_n = 1'b1; xtype = '0;
    repeat (2) tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_n = 1'b1; xtype = '0; addr_claimed = 1'b0; data_done = 1'b0;
    repeat (3) tick();
    check("R1 ack during reset", addr_ack_n, 1);
    check("R1 err during reset", xfer_err_n, 1);
    rst_n = 1'b1;
    observe(10, 0, 0, 0, -1, 5'b0);
    check("R1 ack idle after reset", ack_cnt, 0);
    check("R1 err idle after reset", err_cnt, 0);
  endtask

  task automatic t_addr_only(input logic [4:0] tt, input string tag);
    launch(tt, 1'b0);
    observe(TO + 10, 0, 0, 0, -1, 5'b0);
    check({tag, " ack cycle"}, ack_at, 3);
    check({tag, " ack width R10"}, ack_cnt, 1);
    check({tag, " R4 no error"}, err_cnt, 0);
    check({tag, " R10 overlap"}, both_cnt, 0);
  endtask

  task automatic t_expire(input logic [4:0] tt, input string tag);
    launch(tt, 1'b0);
    observe(TO + 10, 0, 0, 0, -1, 5'b0);
    check({tag, " R6 err cycle"}, err_at, TO);
    check({tag, " R10 err width"}, err_cnt, 1);
    check({tag, " R5 no ack"}, ack_cnt, 0);
  endtask

  task automatic t_claim(input int at, input int exp_err);
    launch(5'b00000, 1'b0);
    observe(TO + 20, at, TO + 15, 0, -1, 5'b0);
    check("R7 claim vs watchdog", err_cnt, exp_err);
  endtask

  task automatic t_done(input int at, input int exp_err);
    launch(5'b01000, 1'b0);
    observe(TO + 10, 0, at, 0, -1, 5'b0);
    check("R8 done vs watchdog", err_cnt, exp_err);
  endtask

  task automatic t_claim_at_start();
    launch(5'b00000, 1'b1);
    observe(TO + 10, 0, 0, 0, -1, 5'b0);
    check("R11 claim with start", err_cnt, 0);
    start_n = 1'b1;
    data_done = 1'b1; tick(); data_done = 1'b0; tick();
  endtask

  task automatic t_busy();
    launch(5'b00010, 1'b0);
    observe(TO + 10, 0, 0, 1, 3, 5'b00000);
    check("R9 starts during addr-only ignored err", err_cnt, 0);
    check("R9 ack still once", ack_cnt, 1);
    launch(5'b00010, 1'b0);
    observe(TO + 10, 0, 0, 4, 4, 5'b00000);
    check("R9 start after ack accepted", err_at, 4 + TO);
    launch(5'b00000, 1'b0);
    observe(TO + 10, 0, 0, 2, TO, 5'b00010);
    check("R9 starts during watchdog ignored ack", ack_cnt, 0);
    check("R9 err single", err_cnt, 1);
  endtask

  initial begin
    t_reset();
    t_addr_only(5'b00010, "R3 plain");
    t_addr_only(5'b10110, "R2 other bits set");
    t_expire(5'b00000, "R6 zero type");
    t_expire(5'b11101, "R2 bit1 clear");
    t_claim(1, 0);
    t_claim(TO - 1, 0);
    t_claim(TO, 1);
    t_done(5, 0);
    t_done(TO - 1, 0);
    t_done(TO, 1);
    t_claim_at_start();
    t_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule